// File: doc/BRIEF.md
# Edge Capture Channel with Overrun Detection

This block timestamps the edges of one external signal against a free-running down-counter. The incoming pin is first gated by a pad enable and then optionally inverted. A two-stage synchronizer follows, and edges are detected after it. When capture is enabled, a rising edge copies the counter into a rising-edge latch and a falling edge copies it into a falling-edge latch.

Each latch has a sticky "new value" indicator that software acknowledges with a one-cycle clear pulse. A second capture arriving before that acknowledgement raises an overrun flag, which clears together with its indicator. A capture interrupt flag can be armed separately for each edge direction.

Either edge can also restart the counter from its period value, so the latched numbers can measure intervals directly. A cascade setting widens the counter and both latches from one half word to a full word, so that long intervals can be timed.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, count, both latches, both indicators, both overrun flags and the interrupt flag are all zero.
- R2: The conditioned input is (cap_pin AND cfg_pad_en) XOR cfg_invert. It passes through two synchronizer flops before edge detection. A pin change driven before clock edge k therefore updates a latch at edge k+2, and the latch holds the count as it stood just before that edge.
- R3: A rising edge of the conditioned input stores count into rise_latch. A falling edge stores count into fall_latch.
- R4: While cfg_cap_en is 0, no edge updates a latch, sets an indicator or overrun flag, sets the interrupt flag, or reloads the counter.
- R5: Each captured edge sets its indicator. A one-cycle clr_rise_ind or clr_fall_ind pulse clears the matching indicator. If a set and a clear arrive in the same cycle, the set wins.
- R6: A capture that arrives while its indicator is already 1, with no clear in that cycle, sets the matching overrun flag. A clear pulse of the indicator also clears the overrun flag, even when it coincides with a new capture.
- R7: cap_irq is set by a captured rising edge when cfg_rise_ie is 1 and by a captured falling edge when cfg_fall_ie is 1. A clr_irq pulse clears it, and a new set in the same cycle wins.
- R8: With cfg_rise_reload (or cfg_fall_reload) set, a captured rising (or falling) edge loads the counter with the period value at the same edge that updates the latch. This applies whether or not cnt_run is 1.
- R9: While cnt_run is 1, the counter decrements by one per clock and loads the period value in place of wrapping below zero. While cnt_run is 0, it holds. Without cascade, the period is period_lo and bits 31:16 of count stay zero.
- R10: With cfg_cascade set, the period is {period_hi, period_lo} and the counter and both latches carry all 32 bits, the upper half word in bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | 1 | Asynchronous capture input from the pad |
| cfg_invert | input | 1 | Invert the gated input |
| cfg_pad_en | input | 1 | Pass the pad input (0 forces it low before inversion) |
| cfg_cap_en | input | 1 | Enable capture |
| cfg_rise_ie | input | 1 | Rising edges set cap_irq |
| cfg_fall_ie | input | 1 | Falling edges set cap_irq |
| cfg_rise_reload | input | 1 | Rising capture reloads the counter |
| cfg_fall_reload | input | 1 | Falling capture reloads the counter |
| cfg_cascade | input | 1 | Full-word counting and capture |
| cnt_run | input | 1 | Counter decrements when 1 |
| period_lo | input | 16 | Period, lower half word |
| period_hi | input | 16 | Period, upper half word (cascade only) |
| clr_rise_ind | input | 1 | Clear pulse for rising indicator and its overrun |
| clr_fall_ind | input | 1 | Clear pulse for falling indicator and its overrun |
| clr_irq | input | 1 | Clear pulse for cap_irq |
| count | output | 32 | Current down-counter value |
| rise_latch | output | 32 | Count stored on the last rising capture |
| fall_latch | output | 32 | Count stored on the last falling capture |
| rise_ind | output | 1 | Rising latch holds an unacknowledged value |
| fall_ind | output | 1 | Falling latch holds an unacknowledged value |
| rise_ovr | output | 1 | Rising latch overwritten before acknowledgement |
| fall_ovr | output | 1 | Falling latch overwritten before acknowledgement |
| cap_irq | output | 1 | Capture interrupt flag |

## Verification
The hardest case to reach from the ports is a software clear that lands in exactly the same cycle as a new capture. In that cycle the indicator must stay set while the overrun flag drops. The bench reaches it by counting the synchronizer latency: it drives the pin edge, waits two falling clock edges, and holds the clear pulse across the third rising edge. The cascade borrow from bit 16 into the lower half word is reached by restarting the counter through a capture reload with a small upper period. A per-cycle behavioural model then checks every output against that timing.

// File: rtl/ecap_pkg.sv
package ecap_pkg;

  typedef struct packed {
    logic invert;
    logic pad_en;
    logic cap_en;
    logic rise_ie;
    logic fall_ie;
    logic rise_reload;
    logic fall_reload;
    logic cascade;
  } ecap_cfg_t;

  // Pad gating happens before inversion.
  function automatic logic condition_input(logic pin, logic pad_en, logic invert);
    return (pin & pad_en) ^ invert;
  endfunction

  // Sticky flag update: a set always wins over a clear.
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/ecap_sync_edge.sv
module ecap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[0..STAGES-1] form the synchronizer, sh[STAGES] holds the previous value.
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/ecap_counter.sv
module ecap_counter #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                cascade,
  input  logic                reload,
  input  logic [HALF_W-1:0]   period_lo,
  input  logic [HALF_W-1:0]   period_hi,
  output logic [2*HALF_W-1:0] count
);
  localparam int CW = 2 * HALF_W;

  function automatic logic [CW-1:0] next_count(
    logic [CW-1:0] cur, logic [HALF_W-1:0] plo, logic [HALF_W-1:0] phi,
    logic go, logic casc, logic rl);
    logic [CW-1:0] per;
    logic [CW-1:0] nxt;
    per = casc ? {phi, plo} : {{HALF_W{1'b0}}, plo};
    if (rl)              nxt = per;
    else if (!go)        nxt = cur;
    else if (cur == '0)  nxt = per;
    else                 nxt = cur - 1'b1;
    if (!casc) nxt[CW-1:HALF_W] = '0;
    return nxt;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, period_lo, period_hi, run, cascade, reload);
  end
endmodule

// File: rtl/ecap_flag.sv
module ecap_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic ind,
  output logic ovr
);
  import ecap_pkg::*;

  logic ovr_set;
  assign ovr_set = set & ind & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ind <= 1'b0;
      ovr <= 1'b0;
    end else begin
      ind <= sticky_next(ind, set, clr);
      ovr <= ovr_set | (ovr & ~clr);
    end
  end
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int HALF_W = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_pin,
  input  logic              cfg_invert,
  input  logic              cfg_pad_en,
  input  logic              cfg_cap_en,
  input  logic              cfg_rise_ie,
  input  logic              cfg_fall_ie,
  input  logic              cfg_rise_reload,
  input  logic              cfg_fall_reload,
  input  logic              cfg_cascade,
  input  logic              cnt_run,
  input  logic [HALF_W-1:0] period_lo,
  input  logic [HALF_W-1:0] period_hi,
  input  logic              clr_rise_ind,
  input  logic              clr_fall_ind,
  input  logic              clr_irq,
  output logic [CW-1:0]     count,
  output logic [CW-1:0]     rise_latch,
  output logic [CW-1:0]     fall_latch,
  output logic              rise_ind,
  output logic              fall_ind,
  output logic              rise_ovr,
  output logic              fall_ovr,
  output logic              cap_irq
);
  import ecap_pkg::*;

  ecap_cfg_t cfg;
  assign cfg = '{invert: cfg_invert, pad_en: cfg_pad_en, cap_en: cfg_cap_en,
                 rise_ie: cfg_rise_ie, fall_ie: cfg_fall_ie,
                 rise_reload: cfg_rise_reload, fall_reload: cfg_fall_reload,
                 cascade: cfg_cascade};

  // Named internal events, also observed by the checker.
  logic cond_in;
  logic rise_edge, fall_edge;
  logic rise_cap, fall_cap;
  logic reload_hit;
  logic irq_set;

  assign cond_in = condition_input(cap_pin, cfg.pad_en, cfg.invert);

  ecap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(cond_in), .rise(rise_edge), .fall(fall_edge)
  );

  assign rise_cap   = rise_edge & cfg.cap_en;
  assign fall_cap   = fall_edge & cfg.cap_en;
  assign reload_hit = (rise_cap & cfg.rise_reload) | (fall_cap & cfg.fall_reload);
  assign irq_set    = (rise_cap & cfg.rise_ie) | (fall_cap & cfg.fall_ie);

  ecap_counter #(.HALF_W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(cnt_run), .cascade(cfg.cascade),
    .reload(reload_hit), .period_lo(period_lo), .period_hi(period_hi), .count(count)
  );

  // Index 0 serves rising edges, index 1 falling edges.
  logic [1:0]          evt;
  logic [1:0]          clr_v;
  logic [1:0]          ind_v;
  logic [1:0]          ovr_v;
  logic [1:0][CW-1:0]  latch_v;

  assign evt   = {fall_cap, rise_cap};
  assign clr_v = {clr_fall_ind, clr_rise_ind};

  for (genvar e = 0; e < 2; e++) begin : g_edge
    ecap_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(evt[e]), .clr(clr_v[e]),
      .ind(ind_v[e]), .ovr(ovr_v[e])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      latch_v[e] <= '0;
      else if (evt[e]) latch_v[e] <= count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cap_irq <= 1'b0;
    else        cap_irq <= sticky_next(cap_irq, irq_set, clr_irq);
  end

  assign rise_latch = latch_v[0];
  assign fall_latch = latch_v[1];
  assign rise_ind   = ind_v[0];
  assign fall_ind   = ind_v[1];
  assign rise_ovr   = ovr_v[0];
  assign fall_ovr   = ovr_v[1];
endmodule

// File: rtl/edge_capture_unit_chk.sv
module edge_capture_unit_chk #(
  parameter int HALF_W = 16,
  localparam int CW = 2 * HALF_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_cap_en,
  input logic              cfg_rise_ie,
  input logic              cfg_rise_reload,
  input logic              cfg_cascade,
  input logic [HALF_W-1:0] period_lo,
  input logic [HALF_W-1:0] period_hi,
  input logic              clr_rise_ind,
  input logic              rise_cap,
  input logic              fall_cap,
  input logic [CW-1:0]     count,
  input logic [CW-1:0]     rise_latch,
  input logic [CW-1:0]     fall_latch,
  input logic              rise_ind,
  input logic              rise_ovr,
  input logic              fall_ind,
  input logic              fall_ovr,
  input logic              cap_irq
);
  // R3
  a_r3_rise_latch_takes_count: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cap |=> rise_latch == $past(count));
  // R4
  a_r4_disabled_latches_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cap_en |=> $stable(rise_latch) && $stable(fall_latch));
  // R5
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cap |=> rise_ind);
  a_r5_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rise_ind && !rise_cap |=> !rise_ind);
  // R6
  a_r6_rise_ovr_needs_ind: assert property (@(posedge clk) disable iff (!rst_n)
    rise_ovr |-> rise_ind);
  a_r6_fall_ovr_needs_ind: assert property (@(posedge clk) disable iff (!rst_n)
    fall_ovr |-> fall_ind);
  // R7
  a_r7_rise_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cap && cfg_rise_ie |=> cap_irq);
  // R8
  a_r8_rise_reload: assert property (@(posedge clk) disable iff (!rst_n)
    rise_cap && cfg_rise_reload && cfg_cascade |=> count == $past({period_hi, period_lo}));
  // R9
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cascade |=> count[CW-1:HALF_W] == '0);
  // R2
  a_r2_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_cap, fall_cap}));
endmodule

bind edge_capture_unit edge_capture_unit_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cap_en(cfg_cap_en), .cfg_rise_ie(cfg_rise_ie),
  .cfg_rise_reload(cfg_rise_reload), .cfg_cascade(cfg_cascade),
  .period_lo(period_lo), .period_hi(period_hi), .clr_rise_ind(clr_rise_ind),
  .rise_cap(rise_cap), .fall_cap(fall_cap), .count(count),
  .rise_latch(rise_latch), .fall_latch(fall_latch), .rise_ind(rise_ind),
  .rise_ovr(rise_ovr), .fall_ind(fall_ind), .fall_ovr(fall_ovr), .cap_irq(cap_irq)
);

// File: tb/edge_capture_unit_test.sv
module edge_capture_unit_test;
  localparam int CLK_P = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic cap_pin = 0, cfg_invert = 0, cfg_pad_en = 0, cfg_cap_en = 0;
  logic cfg_rise_ie = 0, cfg_fall_ie = 0, cfg_rise_reload = 0, cfg_fall_reload = 0;
  logic cfg_cascade = 0, cnt_run = 0;
  logic [15:0] period_lo = 0, period_hi = 0;
  logic clr_rise_ind = 0, clr_fall_ind = 0, clr_irq = 0;
  logic [31:0] count, rise_latch, fall_latch;
  logic rise_ind, fall_ind, rise_ovr, fall_ovr, cap_irq;

  int n_chk = 0, n_fail = 0;
  bit compare_on = 0;

  always #(CLK_P/2) clk = ~clk;

  edge_capture_unit uut (.*);

  // Behavioural reference model
  bit  q1, q2, q3;
  longint m_cnt, m_rl, m_fl;
  bit  m_ri, m_fi, m_ro, m_fo, m_irq;
  bit  t_in, t_r, t_f;
  longint t_per, t_nxt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= 0; q2 <= 0; q3 <= 0;
      m_cnt <= 0; m_rl <= 0; m_fl <= 0;
      m_ri <= 0; m_fi <= 0; m_ro <= 0; m_fo <= 0; m_irq <= 0;
    end else begin
      t_in = (cap_pin && cfg_pad_en) != cfg_invert;
      t_r  = cfg_cap_en && q2 && !q3;
      t_f  = cfg_cap_en && !q2 && q3;
      q1 <= t_in; q2 <= q1; q3 <= q2;
      t_per = cfg_cascade ? (longint'(period_hi) * 65536 + period_lo) : longint'(period_lo);
      if ((t_r && cfg_rise_reload) || (t_f && cfg_fall_reload)) t_nxt = t_per;
      else if (!cnt_run) t_nxt = m_cnt;
      else if (m_cnt == 0) t_nxt = t_per;
      else t_nxt = m_cnt - 1;
      if (!cfg_cascade) t_nxt = t_nxt % 65536;
      m_cnt <= t_nxt;
      if (t_r) m_rl <= m_cnt;
      if (t_f) m_fl <= m_cnt;
      m_ri <= t_r ? 1 : (clr_rise_ind ? 0 : m_ri);
      m_fi <= t_f ? 1 : (clr_fall_ind ? 0 : m_fi);
      m_ro <= clr_rise_ind ? 0 : (m_ro || (t_r && m_ri));
      m_fo <= clr_fall_ind ? 0 : (m_fo || (t_f && m_fi));
      m_irq <= ((t_r && cfg_rise_ie) || (t_f && cfg_fall_ie)) ? 1 : (clr_irq ? 0 : m_irq);
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk("R9 count", count, m_cnt);
      chk("R3 rise_latch", rise_latch, m_rl);
      chk("R3 fall_latch", fall_latch, m_fl);
      chk("R5 rise_ind", rise_ind, m_ri);
      chk("R5 fall_ind", fall_ind, m_fi);
      chk("R6 rise_ovr", rise_ovr, m_ro);
      chk("R6 fall_ovr", fall_ovr, m_fo);
      chk("R7 cap_irq", cap_irq, m_irq);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    clr_rise_ind = 1; clr_fall_ind = 1; clr_irq = 1;
    step(1);
    clr_rise_ind = 0; clr_fall_ind = 0; clr_irq = 0;
  endtask

  initial begin
    longint saved_r, saved_f;
    step(3);
    rst_n = 1;
    step(1);
    // R1: reset state
    chk("R1 count", count, 0);
    chk("R1 latches", rise_latch | fall_latch, 0);
    chk("R1 flags", {rise_ind, fall_ind, rise_ovr, fall_ovr, cap_irq}, 0);
    compare_on = 1;

    // Basic capture and latency
    period_lo = 20; cnt_run = 1; cfg_pad_en = 1; cfg_cap_en = 1;
    cfg_rise_ie = 1; cfg_fall_ie = 1;
    step(5);
    cap_pin = 1;
    step(2);
    chk("R2 no capture after two edges", rise_ind, 0);
    step(1);
    chk("R2 capture on third edge", rise_ind, 1);
    cap_pin = 0;
    step(8);
    clear_all();
    step(3);

    // Overrun on both latches
    cap_pin = 1; step(5); cap_pin = 0; step(5);
    cap_pin = 1; step(5); cap_pin = 0; step(5);
    chk("R6 rise overrun set", rise_ovr, 1);
    chk("R6 fall overrun set", fall_ovr, 1);
    // Clear colliding with a new rising capture
    cap_pin = 1;
    step(2);
    clr_rise_ind = 1;
    step(1);
    clr_rise_ind = 0;
    chk("R5 set wins over clear", rise_ind, 1);
    chk("R6 clear drops overrun", rise_ovr, 0);
    step(3);
    cap_pin = 0; step(5);
    clear_all();
    step(2);

    // Inversion and pad gating
    cfg_cap_en = 0; cfg_invert = 1; step(5);
    cfg_cap_en = 1; step(2);
    cap_pin = 1; step(5);
    chk("R2 inverted pin gives falling capture", fall_ind, 1);
    cap_pin = 0; step(5);
    clear_all();
    cfg_pad_en = 0; step(4);
    saved_r = rise_latch; saved_f = fall_latch;
    cap_pin = 1; step(5); cap_pin = 0; step(5);
    chk("R2 gated pad gives no capture", {rise_ind, fall_ind}, 0);
    chk("R2 gated pad leaves latch", rise_latch, saved_r);
    cfg_cap_en = 0; cfg_invert = 0; cfg_pad_en = 1; step(5);
    clear_all();

    // Capture disabled
    saved_r = rise_latch; saved_f = fall_latch;
    cap_pin = 1; step(5); cap_pin = 0; step(5);
    chk("R4 rise latch unchanged", rise_latch, saved_r);
    chk("R4 fall latch unchanged", fall_latch, saved_f);
    chk("R4 no flags or irq", {rise_ind, fall_ind, cap_irq}, 0);

    // Interrupt per direction
    cfg_cap_en = 1; cfg_rise_ie = 0; cfg_fall_ie = 1; step(2);
    cap_pin = 1; step(5);
    chk("R7 rising edge ignored without enable", cap_irq, 0);
    cap_pin = 0; step(5);
    chk("R7 falling edge raises irq", cap_irq, 1);
    clear_all();
    cfg_rise_ie = 1;

    // Reload on edges
    cfg_rise_reload = 1; period_lo = 40;
    cap_pin = 1; step(3);
    chk("R8 rising reload", count, 40);
    step(4);
    cfg_fall_reload = 1; period_lo = 33;
    cap_pin = 0; step(3);
    chk("R8 falling reload", count, 33);
    cfg_fall_reload = 0;
    step(5);
    clear_all();

    // Cascade
    cfg_cascade = 1; period_hi = 1; period_lo = 3;
    cap_pin = 1; step(3);
    chk("R10 cascade reload", count, 32'h0001_0003);
    step(4);
    chk("R10 borrow across halves", count, 32'h0000_FFFF);
    cap_pin = 0; step(6);
    cap_pin = 1; step(6);
    cfg_rise_reload = 0;
    step(10);

    // Stop and leave cascade
    cnt_run = 0; step(5);
    cfg_cascade = 0; step(5);
    chk("R9 upper half cleared without cascade", count[31:16], 0);
    step(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule